// File: doc/BRIEF.md
# Masked Vector Lane Move Unit

This block moves a packed vector of 32-bit lanes from a source operand into a destination register image of up to 512 bits. Each lane in the active vector length is either copied from the source, left at its old destination value, or cleared, depending on a per-lane writemask, a merge/zero choice, and whether the operation is a store or a load/register copy. Bits above the active vector length are cleared, preserved, or left untouched. This depends on the encoding class and on the form.

A caller presents the source, the old destination value and the control fields together with a valid strobe. One cycle later the new destination image and a fault flag appear with an output valid. If the 4-bit reserved specifier field is anything other than all ones, the move is refused: the fault flag is raised and the old destination passes through unmodified. Lane bits are copied bit-exactly. No floating-point interpretation takes place.

Top module: `vec_lane_move`

## Requirements
- R1: With the masked encoding (enc_i = 2 or 3), a lane inside the active length whose mask bit is 1 takes the source lane bit-exactly. Lane j occupies bits 32*j+31 down to 32*j. The active lane count is 4, 8 or 16 for vl_sel_i = 0, 1, or 2/3.
- R2: In load/copy form (store_i = 0) with the masked encoding and zero_i = 0, a masked-off lane inside the active length keeps its old destination value.
- R3: In load/copy form with the masked encoding and zero_i = 1, a masked-off lane inside the active length is cleared to zero.
- R4: In store form (store_i = 1), a masked-off lane keeps its old destination value whatever zero_i is.
- R5: In load/copy form with the masked encoding, every lane at or above the active length is cleared.
- R6: With the plain extended encoding (enc_i = 1), mask_i and zero_i have no effect. All active lanes are copied, and in load/copy form all lanes above the active length are cleared.
- R7: With the legacy encoding (enc_i = 0), the active length is 4 lanes regardless of vl_sel_i, and mask_i has no effect. In load/copy form, bits 511 down to 128 keep their old values.
- R8: In store form, every lane at or above the active length keeps its old destination value for all encodings.
- R9: When resv_i is not 4'b1111, fault_o is 1 and dst_o equals dst_old_i. Otherwise fault_o is 0.
- R10: dst_o, fault_o and valid_o update one cycle after a cycle with valid_i = 1. valid_o is 0 otherwise. dst_o and fault_o hold when valid_i is 0. Reset clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Inputs valid this cycle |
| src_i | input | 512 | Source vector |
| dst_old_i | input | 512 | Old destination value |
| mask_i | input | 16 | Per-lane writemask, bit j for lane j |
| vl_sel_i | input | 2 | Vector length: 0=128, 1=256, 2/3=512 |
| enc_i | input | 2 | Encoding: 0 legacy, 1 plain extended, 2/3 masked |
| store_i | input | 1 | 1 = store form, 0 = load/register copy |
| zero_i | input | 1 | Zeroing masking select |
| resv_i | input | 4 | Reserved specifier field, must be 4'b1111 |
| valid_o | output | 1 | Output valid |
| dst_o | output | 512 | New destination value |
| fault_o | output | 1 | Undefined-opcode fault |

## Verification
The hardest case is a lane that needs three conditions at once: it sits above the active length, it is masked off, and it carries a nonzero old value. Only then do clearing, merging and preserving give different results. The stimulus therefore always uses distinct nonzero old and source patterns. It sweeps each encoding against each length and each form, and it uses sparse masks with zero_i in both states. Fault cases carry legal-looking masks and lengths, so that the pass-through of the old value is visible rather than coincidental.

// File: rtl/vlm_pkg.sv
package vlm_pkg;
  localparam int LANE_W = 32;
  localparam int LANES  = 16;
  localparam int DATA_W = LANE_W * LANES;
  localparam int RESV_W = 4;
  localparam int VLS_W  = 2;
  localparam int ENC_W  = 2;
  localparam logic [ENC_W-1:0] ENC_LEGACY = 2'd0;
  localparam logic [ENC_W-1:0] ENC_PLAIN  = 2'd1;
endpackage

// File: rtl/vlm_ctrl.sv
module vlm_ctrl
  import vlm_pkg::*;
#(
  parameter int N_LANES = LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_LANES-1:0] mask_i,
  input  logic [VLS_W-1:0]  vl_sel_i,
  input  logic [ENC_W-1:0]  enc_i,
  input  logic              store_i,
  input  logic              zero_i,
  input  logic [RESV_W-1:0] resv_i,
  output logic [N_LANES-1:0] copy_o,
  output logic [N_LANES-1:0] clr_o,
  output logic              fault_o
);
  localparam int KL_W = $clog2(N_LANES + 1);

  logic [KL_W-1:0] kl;
  logic            masked_enc;

  assign fault_o    = (resv_i != {RESV_W{1'b1}});
  assign masked_enc = (enc_i != ENC_LEGACY) && (enc_i != ENC_PLAIN);

  always_comb begin
    if (enc_i == ENC_LEGACY || vl_sel_i == 2'd0) kl = KL_W'(N_LANES / 4);
    else if (vl_sel_i == 2'd1)                   kl = KL_W'(N_LANES / 2);
    else                                         kl = KL_W'(N_LANES);
  end

  for (genvar j = 0; j < N_LANES; j++) begin : g_lane
    logic in_vl, m_eff;
    assign in_vl    = (KL_W'(j) < kl);
    assign m_eff    = masked_enc ? mask_i[j] : 1'b1;
    assign copy_o[j] = !fault_o && in_vl && m_eff;
    // upper lanes cleared unless legacy; active masked-off lanes only under zeroing
    assign clr_o[j]  = !fault_o && !copy_o[j] && !store_i &&
                       (in_vl ? (masked_enc && zero_i) : (enc_i != ENC_LEGACY));
  end

  // R4
  store_no_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_i |-> (clr_o == '0));
  // R9
  fault_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> ((copy_o | clr_o) == '0));
endmodule

// File: rtl/vlm_lane.sv
module vlm_lane #(
  parameter int W = 32
) (
  input  logic         copy_i,
  input  logic         clr_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] old_i,
  output logic [W-1:0] lane_o
);
  always_comb begin
    if (copy_i)     lane_o = src_i;
    else if (clr_i) lane_o = '0;
    else            lane_o = old_i;
  end
endmodule

// File: rtl/vec_lane_move.sv
module vec_lane_move
  import vlm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_old_i,
  input  logic [LANES-1:0]  mask_i,
  input  logic [VLS_W-1:0]  vl_sel_i,
  input  logic [ENC_W-1:0]  enc_i,
  input  logic              store_i,
  input  logic              zero_i,
  input  logic [RESV_W-1:0] resv_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] dst_o,
  output logic              fault_o
);
  localparam int LOW_W = LANE_W * LANES / 4;

  logic [LANES-1:0]  copy, clr;
  logic              fault;
  logic [DATA_W-1:0] dst_nxt;

  vlm_ctrl #(.N_LANES(LANES)) u_ctrl (
    .clk_i, .rst_ni, .mask_i, .vl_sel_i, .enc_i, .store_i, .zero_i, .resv_i,
    .copy_o(copy), .clr_o(clr), .fault_o(fault)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    vlm_lane #(.W(LANE_W)) u_lane (
      .copy_i(copy[j]),
      .clr_i (clr[j]),
      .src_i (src_i[j*LANE_W +: LANE_W]),
      .old_i (dst_old_i[j*LANE_W +: LANE_W]),
      .lane_o(dst_nxt[j*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      dst_o   <= '0;
      fault_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        dst_o   <= dst_nxt;
        fault_o <= fault;
      end
    end
  end

  // R10
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(dst_o) && $stable(fault_o)));
  // R9
  fault_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && resv_i != 4'hF) |=> (fault_o && dst_o == $past(dst_old_i)));
  // R7
  legacy_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && enc_i == ENC_LEGACY) |=>
      (dst_o[DATA_W-1:LOW_W] == $past(dst_old_i[DATA_W-1:LOW_W])));
endmodule

// File: tb/vec_lane_move_tb.sv
module vec_lane_move_tb;
  localparam int LW = 32;
  localparam int NL = 16;
  localparam int DW = LW * NL;

  typedef struct {
    logic [DW-1:0] d;
    logic          f;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_i = 1'b0;
  logic [DW-1:0] src = '0, old = '0;
  logic [NL-1:0] mask = '0;
  logic [1:0]    vl = '0, enc = '0;
  logic          st = 1'b0, zr = 1'b0;
  logic [3:0]    resv = 4'hF;
  logic          valid_o, fault_o;
  logic [DW-1:0] dst_o;

  int   n_tests = 0, n_fail = 0;
  exp_t q[$];
  exp_t last;

  always #2.5 clk = ~clk;

  vec_lane_move u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .src_i(src), .dst_old_i(old),
    .mask_i(mask), .vl_sel_i(vl), .enc_i(enc), .store_i(st), .zero_i(zr),
    .resv_i(resv), .valid_o(valid_o), .dst_o(dst_o), .fault_o(fault_o)
  );

  function automatic exp_t model(logic [DW-1:0] s, logic [DW-1:0] o, logic [NL-1:0] m,
                                 logic [1:0] v, logic [1:0] e, logic is_st, logic z,
                                 logic [3:0] r, string tag);
    exp_t x;
    int kl;
    logic masked;
    x.tag = tag;
    x.f   = (r != 4'hF);
    x.d   = o;
    masked = (e >= 2);
    kl = (e == 0 || v == 0) ? 4 : (v == 1) ? 8 : 16;
    if (!x.f) begin
      for (int j = 0; j < NL; j++) begin
        if (j < kl) begin
          if (!masked || m[j]) x.d[j*LW +: LW] = s[j*LW +: LW];          // R1 R6 R7
          else if (!is_st && z) x.d[j*LW +: LW] = '0;                   // R3
        end else if (!is_st && e != 0) x.d[j*LW +: LW] = '0;           // R5 R6
      end
    end
    return x;
  endfunction

  function automatic logic [DW-1:0] rvec();
    logic [DW-1:0] v;
    for (int j = 0; j < NL; j++) v[j*LW +: LW] = $urandom();
    return v;
  endfunction

  task automatic send(logic [DW-1:0] s, logic [DW-1:0] o, logic [NL-1:0] m, logic [1:0] v,
                      logic [1:0] e, logic is_st, logic z, logic [3:0] r, string tag);
    @(negedge clk);
    src = s; old = o; mask = m; vl = v; enc = e; st = is_st; zr = z; resv = r;
    valid_i = 1'b1;
    q.push_back(model(s, o, m, v, e, is_st, z, r, tag));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      src = rvec(); old = rvec(); mask = 16'h0F0F; resv = 4'h0;
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && valid_o) begin
        n_tests++;
        if (q.size() == 0) begin
          n_fail++;
          $display("FAIL R10: unexpected valid_o, act=1 exp=0");
        end else begin
          e = q.pop_front();
          last = e;
          if (dst_o !== e.d || fault_o !== e.f) begin
            n_fail++;
            $display("FAIL %s: act dst=%h f=%b exp dst=%h f=%b", e.tag, dst_o, fault_o, e.d, e.f);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : driver
    logic [DW-1:0] a, b;
    a = rvec(); b = rvec();
    src = a; old = b;
    repeat (3) @(posedge clk);
    #1;
    n_tests++;
    if (dst_o !== '0 || fault_o !== 1'b0 || valid_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 reset: act dst=%h f=%b v=%b exp 0", dst_o, fault_o, valid_o);
    end
    @(negedge clk);
    rst_n = 1'b1;

    send(a, b, 16'hFFFF, 2'd2, 2'd2, 1'b0, 1'b0, 4'hF, "R1 full copy 512");
    send(a, b, 16'h5A5A, 2'd2, 2'd2, 1'b0, 1'b0, 4'hF, "R2 merge 512");
    send(a, b, 16'h5A5A, 2'd2, 2'd3, 1'b0, 1'b1, 4'hF, "R3 zero 512");
    send(a, b, 16'h00A5, 2'd1, 2'd2, 1'b0, 1'b0, 4'hF, "R5 masked 256 upper clear");
    send(a, b, 16'h0003, 2'd0, 2'd2, 1'b0, 1'b1, 4'hF, "R5 masked 128 zero");
    send(a, b, 16'h3C3C, 2'd2, 2'd2, 1'b1, 1'b1, 4'hF, "R4 store zero ignored");
    send(a, b, 16'h0009, 2'd0, 2'd2, 1'b1, 1'b0, 4'hF, "R8 store 128 upper kept");
    send(a, b, 16'h0000, 2'd1, 2'd1, 1'b0, 1'b1, 4'hF, "R6 plain 256 mask ignored");
    send(a, b, 16'h0000, 2'd0, 2'd1, 1'b1, 1'b0, 4'hF, "R8 plain store 128");
    send(a, b, 16'h0000, 2'd2, 2'd0, 1'b0, 1'b1, 4'hF, "R7 legacy vl ignored");
    send(a, b, 16'hFFFF, 2'd0, 2'd0, 1'b1, 1'b0, 4'hF, "R7 legacy store");
    send(a, b, 16'hFFFF, 2'd2, 2'd2, 1'b0, 1'b1, 4'hE, "R9 fault 1110");
    send(a, b, 16'hFFFF, 2'd0, 2'd1, 1'b0, 1'b0, 4'h0, "R9 fault 0000");
    send(b, a, 16'h8001, 2'd2, 2'd2, 1'b0, 1'b0, 4'hF, "R2 edge lanes");
    idle(4);
    n_tests++;
    if (dst_o !== last.d || fault_o !== last.f || valid_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R10 hold: act dst=%h f=%b v=%b exp dst=%h f=%b v=0",
               dst_o, fault_o, valid_o, last.d, last.f);
    end

    for (int i = 0; i < 300; i++) begin
      logic [3:0] r;
      r = ($urandom_range(0, 7) == 0) ? 4'($urandom()) : 4'hF;
      send(rvec(), rvec(), 16'($urandom()), 2'($urandom()), 2'($urandom()),
           1'($urandom()), 1'($urandom()), r, "R1 R4 R5 R6 R7 R8 R9 random");
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    idle(3);
    n_tests++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R10: act pending=%0d exp=0", q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule